// File: doc/BRIEF.md
# Read Latency Start Value Calculator

This block works out where a DDR3 read-latency sweep should begin, and how much guard to add once a passing setting is found. A single start pulse captures a set of register-derived fields. The block then sums latency contributions in half memory-clock units, doubles the sum to quarter units, and converts the result into northbridge clocks. The conversion uses the ratio of a northbridge frequency factor to a memory-clock divisor, with a round-up rule. In the same run it derives a guard value of one memory clock plus one northbridge clock.

All four divisions go through one restoring shift-subtract divider, run one after another. When both results are ready, a one-cycle done strobe marks them. The results then stay on the outputs until the next run finishes.

Top module: `rd_lat_start_calc`

## Requirements
- R1: The half-unit subtotal is 2×(cas+1), plus 2 when `dimm_unbuf` is 0, plus 2 when any of `setup_addr`, `setup_cs`, `setup_cke` is 1 and plus 1 when none is, plus 8 minus `rdptr_code`, plus `rcven_dly[7:5]`. It is computed modulo 128, so codes above 8 can wrap it.
- R2: The quarter-unit subtotal Q is twice the half-unit subtotal, taken as an 8-bit value.
- R3: From the 3-bit `mclk_code` m, the memory factor is 2m when m ≥ 3 and m+3 otherwise. The divisor D is 4 times the memory factor.
- R4: The northbridge factor N is (`nb_fid` + 4) × 3.
- R5: `start_lat` is q = floor(N×Q / D), plus 1 when q mod D is nonzero.
- R6: `margin` is p = floor(4N / D), plus 1 when p mod D is nonzero, plus 1. It is therefore never 0.
- R7: All inputs are captured at the clock edge where `start` is seen while idle. Input changes after that edge do not alter the results of that run.
- R8: A `start` that arrives while a computation is running is ignored. The running job keeps its captured inputs, finishes on its normal schedule, and produces exactly one done strobe.
- R9: `done` goes high for exactly one cycle, 4×DW+5 clock edges after the capturing edge.
- R10: After reset, `done`, `start_lat` and `margin` are 0. The outputs change only together with a done strobe and hold their values otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a computation when idle |
| cas_code | input | 4 | CAS latency code |
| dimm_unbuf | input | 1 | 1 for unbuffered DIMMs, 0 for registered |
| setup_addr | input | 1 | Address/command prelaunch setup flag |
| setup_cs | input | 1 | Chip-select/ODT prelaunch setup flag |
| setup_cke | input | 1 | CKE prelaunch setup flag |
| rdptr_code | input | 4 | Read pointer initialisation code |
| rcven_dly | input | 8 | Worst-case receiver-enable delay |
| mclk_code | input | 3 | Memory clock frequency code |
| nb_fid | input | 5 | Northbridge frequency ID |
| done | output | 1 | One-cycle strobe when results are valid |
| start_lat | output | DW | Starting read latency in northbridge clocks |
| margin | output | DW | Guard value in northbridge clocks |

## Verification
The bench builds the block with DW = 16. At that width the largest dividend, 105 × 254 = 26670, still fits. This includes the wrapped subtotals that `rdptr_code` values 9 to 15 produce, so those corners and the extreme `nb_fid` and `mclk_code` values are checked without truncation. The done latency at this width is 69 edges. That schedule leaves room to inject a second start and changed inputs partway through a run.

// File: rtl/rd_lat_start_calc.sv
module rd_lat_start_calc #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [3:0]    cas_code,
  input  logic          dimm_unbuf,
  input  logic          setup_addr,
  input  logic          setup_cs,
  input  logic          setup_cke,
  input  logic [3:0]    rdptr_code,
  input  logic [7:0]    rcven_dly,
  input  logic [2:0]    mclk_code,
  input  logic [4:0]    nb_fid,
  output logic          done,
  output logic [DW-1:0] start_lat,
  output logic [DW-1:0] margin
);
  localparam int CW = (DW > 1) ? $clog2(DW) : 1;
  localparam int FW = 21;

  typedef enum logic [1:0] {S_IDLE, S_LOAD, S_STEP, S_FIN} st_t;
  st_t st;

  logic [FW-1:0] cfg_q;
  logic [1:0]    ph;
  logic [CW-1:0] cnt;
  logic [DW-1:0] quo, rem, q_lat, q_mar, dvd, dvs;
  logic          bump_lat, bump_mar;
  logic          busy;

  logic [3:0] c_cas, c_rdp;
  logic       c_unbuf, c_set;
  logic [2:0] c_rcv, c_m;
  logic [4:0] c_fid;
  assign {c_cas, c_unbuf, c_set, c_rdp, c_rcv, c_m, c_fid} = cfg_q;

  logic [6:0]  half_sub, nbfac;
  logic [7:0]  quarter;
  logic [3:0]  mfac;
  logic [14:0] prod;

  assign half_sub = ({3'b0, c_cas} + 7'd1) * 7'd2
                  + (c_unbuf ? 7'd0 : 7'd2)
                  + (c_set ? 7'd2 : 7'd1)
                  + 7'd8 - {3'b0, c_rdp}
                  + {4'b0, c_rcv};
  assign quarter  = {half_sub, 1'b0};
  assign mfac     = (c_m >= 3'd3) ? {c_m, 1'b0} : {1'b0, c_m} + 4'd3;
  assign nbfac    = ({2'b0, c_fid} + 7'd4) * 7'd3;
  assign prod     = {8'b0, nbfac} * {7'b0, quarter};
  assign dvs      = DW'({mfac, 2'b00});
  assign busy     = (st != S_IDLE);

  always_comb begin
    case (ph)
      2'd0:    dvd = DW'(prod);
      2'd1:    dvd = q_lat;
      2'd2:    dvd = DW'({nbfac, 2'b00});
      default: dvd = q_mar;
    endcase
  end

  logic [DW:0]   diff;
  logic          qbit;
  logic [DW-1:0] nq, nr;
  assign diff = {rem, quo[DW-1]} - {1'b0, dvs};
  assign qbit = ~diff[DW];
  assign nq   = {quo[DW-2:0], qbit};
  assign nr   = qbit ? diff[DW-1:0] : {rem[DW-2:0], quo[DW-1]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      cfg_q     <= '0;
      ph        <= '0;
      cnt       <= '0;
      quo       <= '0;
      rem       <= '0;
      q_lat     <= '0;
      q_mar     <= '0;
      bump_lat  <= 1'b0;
      bump_mar  <= 1'b0;
      done      <= 1'b0;
      start_lat <= '0;
      margin    <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          cfg_q <= {cas_code, dimm_unbuf, setup_addr | setup_cs | setup_cke,
                    rdptr_code, rcven_dly[7:5], mclk_code, nb_fid};
          ph    <= 2'd0;
          st    <= S_LOAD;
        end
        S_LOAD: begin
          quo <= dvd;
          rem <= '0;
          cnt <= '0;
          st  <= S_STEP;
        end
        S_STEP: begin
          quo <= nq;
          rem <= nr;
          cnt <= cnt + 1'b1;
          if (cnt == CW'(DW-1)) begin
            case (ph)
              2'd0:    q_lat    <= nq;
              2'd1:    bump_lat <= (nr != '0);
              2'd2:    q_mar    <= nq;
              default: bump_mar <= (nr != '0);
            endcase
            ph <= ph + 2'd1;
            st <= (ph == 2'd3) ? S_FIN : S_LOAD;
          end
        end
        default: begin
          start_lat <= q_lat + {{(DW-1){1'b0}}, bump_lat};
          margin    <= q_mar + {{(DW-1){1'b0}}, bump_mar} + {{(DW-1){1'b0}}, 1'b1};
          done      <= 1'b1;
          st        <= S_IDLE;
        end
      endcase
    end
  end
endmodule

// File: rtl/rd_lat_start_calc_chk.sv
module rd_lat_start_calc_chk #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          busy,
  input logic          done,
  input logic [DW-1:0] start_lat,
  input logic [DW-1:0] margin,
  input logic [20:0]   cfg_q
);
  p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_done_from_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(busy));
  p_idle_no_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> !done);
  p_cfg_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(cfg_q));
  p_out_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(start_lat) && $stable(margin)));
  p_margin_nonzero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (margin != '0));
endmodule

bind rd_lat_start_calc rd_lat_start_calc_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .start_lat(start_lat), .margin(margin), .cfg_q(cfg_q)
);

// File: tb/rd_lat_start_calc_tb.sv
module rd_lat_start_calc_tb;
  localparam int DW  = 16;
  localparam int LAT = 4*DW+5;

  logic clk = 0, rst_n = 0, start = 0;
  logic [3:0] cas_code = 0, rdptr_code = 0;
  logic dimm_unbuf = 0, setup_addr = 0, setup_cs = 0, setup_cke = 0;
  logic [7:0] rcven_dly = 0;
  logic [2:0] mclk_code = 0;
  logic [4:0] nb_fid = 0;
  logic done;
  logic [DW-1:0] start_lat, margin;

  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  rd_lat_start_calc #(.DW(DW)) u_dut (.*);

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FIN%s %s actual=%0d expected=%0d", "AL", req, act, exp);
    end
  endtask

  function automatic void model(input int cas, unb, anyset, rdp, rcv, m, fid,
                                output int lat, output int mar);
    int half, q4, mf, d, nb, q, p;
    half = 2*(cas+1) + (unb ? 0 : 2) + (anyset ? 2 : 1) + 8 - rdp + (rcv >> 5);
    half = ((half % 128) + 128) % 128;
    q4 = 2*half;
    mf = (m >= 3) ? 2*m : m+3;
    d = 4*mf;
    nb = (fid+4)*3;
    q = (nb*q4)/d;
    lat = q + ((q % d) != 0 ? 1 : 0);
    p = (4*nb)/d;
    mar = p + ((p % d) != 0 ? 1 : 0) + 1;
  endfunction

  task automatic drive(input int cas, unb, sa, sc, sk, rdp, rcv, m, fid);
    cas_code = 4'(cas); dimm_unbuf = 1'(unb);
    setup_addr = 1'(sa); setup_cs = 1'(sc); setup_cke = 1'(sk);
    rdptr_code = 4'(rdp); rcven_dly = 8'(rcv);
    mclk_code = 3'(m); nb_fid = 5'(fid);
  endtask

  task automatic wait_done(output int n);
    n = 0;
    do begin
      @(posedge clk); n++;
      @(negedge clk);
    end while (!done && n < 4*LAT);
  endtask

  task automatic run_case(input string req, input int cas, unb, sa, sc, sk,
                          rdp, rcv, m, fid);
    int n, el, em;
    model(cas, unb, sa|sc|sk, rdp, rcv, m, fid, el, em);
    @(negedge clk);
    drive(cas, unb, sa, sc, sk, rdp, rcv, m, fid);
    start = 1;
    @(posedge clk);
    @(negedge clk);
    start = 0;
    wait_done(n);
    chk({req, " start_lat"}, int'(start_lat), el);
    chk({req, " margin"}, int'(margin), em);
  endtask

  task automatic t_reset;
    chk("R10 reset done", int'(done), 0);
    chk("R10 reset start_lat", int'(start_lat), 0);
    chk("R10 reset margin", int'(margin), 0);
  endtask

  task automatic t_patterns;
    run_case("R1 R5 R6 typical", 5, 1, 0, 0, 0, 6, 8'h45, 2, 10);
    run_case("R1 registered", 5, 0, 0, 0, 0, 6, 8'h45, 2, 10);
    run_case("R1 setup addr", 7, 1, 1, 0, 0, 5, 8'h80, 4, 12);
    run_case("R1 setup cs", 7, 1, 0, 1, 0, 5, 8'h80, 4, 12);
    run_case("R1 setup cke", 7, 1, 0, 0, 1, 5, 8'h80, 4, 12);
    run_case("R1 R2 rcven max", 15, 0, 1, 1, 1, 0, 8'hFF, 7, 31);
    run_case("R1 R2 rdptr wrap", 0, 1, 0, 0, 0, 15, 8'h1F, 3, 31);
    run_case("R4 fid zero", 3, 1, 0, 0, 0, 8, 8'h20, 6, 0);
    for (int m = 0; m < 8; m++)
      run_case("R3 mclk code sweep", 9, 0, 1, 0, 0, 4, 8'hA3, m, 17);
  endtask

  task automatic t_timing;
    int n;
    @(negedge clk);
    drive(4, 1, 0, 1, 0, 7, 8'h60, 5, 20);
    start = 1;
    @(posedge clk);
    @(negedge clk);
    start = 0;
    wait_done(n);
    chk("R9 done latency", n, LAT);
    @(negedge clk);
    chk("R9 done one cycle", int'(done), 0);
  endtask

  task automatic t_capture;
    int n, el, em;
    model(6, 1, 0, 5, 8'hC0, 1, 14, el, em);
    @(negedge clk);
    drive(6, 1, 0, 0, 0, 5, 8'hC0, 1, 14);
    start = 1;
    @(posedge clk);
    @(negedge clk);
    start = 0;
    drive(1, 0, 1, 1, 1, 12, 8'h00, 7, 3);
    wait_done(n);
    chk("R7 captured start_lat", int'(start_lat), el);
    chk("R7 captured margin", int'(margin), em);
  endtask

  task automatic t_busy_start;
    int n, el, em, extra;
    model(2, 0, 1, 7, 8'h40, 3, 25, el, em);
    @(negedge clk);
    drive(2, 0, 1, 0, 0, 7, 8'h40, 3, 25);
    start = 1;
    @(posedge clk);
    @(negedge clk);
    start = 0;
    repeat (10) @(negedge clk);
    drive(11, 1, 0, 0, 0, 2, 8'hE0, 0, 5);
    start = 1;
    @(negedge clk);
    start = 0;
    n = 11;
    do begin
      @(posedge clk); n++;
      @(negedge clk);
    end while (!done && n < 4*LAT);
    chk("R8 latency unchanged", n, LAT);
    chk("R8 start_lat", int'(start_lat), el);
    chk("R8 margin", int'(margin), em);
    extra = 0;
    repeat (LAT + 10) begin
      @(negedge clk);
      if (done) extra++;
    end
    chk("R8 no second done", extra, 0);
    chk("R10 hold start_lat", int'(start_lat), el);
    chk("R10 hold margin", int'(margin), em);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_patterns();
    t_timing();
    t_capture();
    t_busy_start();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule